// File: doc/BRIEF.md
# Setup-Mode I/O Router for a Micro Channel System Board

This block is the system-board decoder for the setup control ports and for the eight-byte option-select window. Two setup registers decide where each window access goes. A system setup byte and an adapter setup byte are involved. An access can go to the planar register file, to a small integrated-video responder, or to one adapter slot. Accesses that no target claims are dropped on writes and return 0xFF on reads.

The same decoder also holds the system control byte. A write that sets bit 0 of that byte produces a one-cycle CPU reset pulse. Bit 1 of the byte drives the alternate A20 gate. The block only produces selects, an offset and a slot index. The targets sit outside it and return their read data on dedicated inputs. The block returns the read data in the same cycle as the read strobe.

Top module: `mca_setup_router`

## Requirements
- R1: After reset, the register at 0x94 reads 0xFF, the register at 0x96 reads 0x70, and the register at 0x92 reads 0x00. After reset, cpu_reset and a20_alt are low.
- R2: While bit 7 of the 0x94 register is 0, every read or write of 0x100–0x107 asserts planar_rd or planar_wr. pos_off carries the address bits 2:0, and a read returns planar_rdata.
- R3: While bit 7 of 0x94 is 1 and bit 5 is 0, a read of 0x100 returns 0xFD and a read of 0x101 returns 0xEF. No select output is asserted.
- R4: While bit 7 of 0x94 is 1 and bit 5 is 0, port 0x102 is a local byte that reads back the last value written there. The byte resets to 0x00, and a write to it asserts no select.
- R5: While bits 7 and 5 of 0x94 are both 1 and bit 3 of the 0x96 register is 1, window accesses assert slot_rd or slot_wr. A read returns slot_rdata. slot_idx always equals bits 2:0 of the 0x96 register.
- R6: Every other window access asserts no select. This covers offsets 3–7 and the write-only offsets 0–1 in video mode, and any access while bit 3 of 0x96 is clear with bits 7 and 5 of 0x94 set. Such a read returns 0xFF, and such a write changes no state.
- R7: A read of 0x96 returns the last value written there with bits 6:4 set.
- R8: A write to 0x92 with data bit 0 = 1 while the stored bit 0 is 0 makes cpu_reset high for exactly the one cycle after the write edge. No other write produces the pulse.
- R9: a20_alt equals bit 1 of the last value written to 0x92, and a read of 0x92 returns that value.
- R10: A read of 0x94 returns the last value written there. A read of any address outside 0x92, 0x94, 0x96 and 0x100–0x107 returns 0xFF.
- R11: No select output is asserted unless the matching io_rd or io_wr strobe is high. At most one select is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rdata | output | 8 | Read data, valid in the cycle of io_rd |
| planar_rdata | input | 8 | Read data from the planar register file |
| slot_rdata | input | 8 | Read data from the selected adapter |
| planar_rd | output | 1 | Planar register read select |
| planar_wr | output | 1 | Planar register write select |
| slot_rd | output | 1 | Adapter read select |
| slot_wr | output | 1 | Adapter write select |
| slot_idx | output | 3 | Selected adapter slot |
| pos_off | output | 3 | Offset inside the option-select window |
| cpu_reset | output | 1 | One-cycle CPU reset pulse |
| a20_alt | output | 1 | Alternate A20 enable |

## Verification
The selects, pos_off and io_rdata are combinational, so they are due in the same cycle as the strobe. The bench drives each access on the falling edge and checks these outputs 5 ns later, before the rising edge that commits any write. Register updates, the A20 level and the reset pulse become visible after that rising edge. The bench checks them at the next falling edge, which is also the only cycle in which the pulse may be high. A reference model that the bench updates after each edge supplies every expected value, so a long random run and the directed corner cases use the same timing.

// File: rtl/mca_router_pkg.sv
package mca_router_pkg;

   // Routing decision for an access inside the option-select window
   typedef enum logic [1:0] {
      RT_NONE   = 2'd0,
      RT_PLANAR = 2'd1,
      RT_VIDEO  = 2'd2,
      RT_SLOT   = 2'd3
   } route_e;

   // Bit positions decoded by the window router
   localparam int unsigned SYS_PLANAR_OFF_BIT = 7;   // 0: planar owns window
   localparam int unsigned SYS_VIDEO_OFF_BIT  = 5;   // 0: integrated video owns window
   localparam int unsigned ADP_ENABLE_BIT     = 3;   // 1: adapter slot forwarding
   localparam int unsigned CTL_RESET_BIT      = 0;
   localparam int unsigned CTL_A20_BIT        = 1;

   // Address class of a bus access
   typedef struct packed {
      logic ctl;
      logic sys;
      logic adp;
      logic win;
   } hit_t;

endpackage

// File: rtl/mca_port_decode.sv
module mca_port_decode
   import mca_router_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned CTL_ADDR = 16'h0092,
   parameter int unsigned SYS_ADDR = 16'h0094,
   parameter int unsigned ADP_ADDR = 16'h0096,
   parameter int unsigned WIN_BASE = 16'h0100,
   parameter int unsigned WIN_SPAN = 8,
   localparam int unsigned OFF_W   = $clog2(WIN_SPAN)
)(
   input  logic [ADDR_W-1:0] addr,
   output hit_t              hit,
   output logic [OFF_W-1:0]  off
);

   logic [ADDR_W-1:0] win_tag;
   logic [ADDR_W-1:0] base_tag;

   assign win_tag  = addr >> OFF_W;
   assign base_tag = ADDR_W'(WIN_BASE) >> OFF_W;

   always_comb begin
      hit     = '0;
      hit.ctl = (addr == ADDR_W'(CTL_ADDR));
      hit.sys = (addr == ADDR_W'(SYS_ADDR));
      hit.adp = (addr == ADDR_W'(ADP_ADDR));
      hit.win = (win_tag == base_tag);
   end

   assign off = addr[OFF_W-1:0];

endmodule

// File: rtl/mca_window_router.sv
module mca_window_router
   import mca_router_pkg::*;
#(
   parameter int unsigned DATA_W = 8
)(
   input  logic [DATA_W-1:0] sys_setup,
   input  logic [DATA_W-1:0] adp_setup,
   output route_e            route
);

   logic planar_own;
   logic video_own;
   logic slot_own;

   assign planar_own = ~sys_setup[SYS_PLANAR_OFF_BIT];
   assign video_own  = sys_setup[SYS_PLANAR_OFF_BIT] & ~sys_setup[SYS_VIDEO_OFF_BIT];
   assign slot_own   = sys_setup[SYS_PLANAR_OFF_BIT] &  sys_setup[SYS_VIDEO_OFF_BIT]
                     & adp_setup[ADP_ENABLE_BIT];

   // Fixed priority: planar, then integrated video, then adapter slot
   always_comb begin
      if (planar_own)
         route = RT_PLANAR;
      else if (video_own)
         route = RT_VIDEO;
      else if (slot_own)
         route = RT_SLOT;
      else
         route = RT_NONE;
   end

endmodule

// File: rtl/mca_ctrl_regs.sv
module mca_ctrl_regs
   import mca_router_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter logic [7:0]  SYS_RESET = 8'hFF,
   parameter logic [7:0]  ADP_RESET = 8'h00,
   parameter logic [7:0]  CTL_RESET = 8'h00,
   parameter logic [7:0]  VID_RESET = 8'h00
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_sys,
   input  logic              wr_adp,
   input  logic              wr_ctl,
   input  logic              wr_vid,
   output logic [DATA_W-1:0] sys_q,
   output logic [DATA_W-1:0] adp_q,
   output logic [DATA_W-1:0] ctl_q,
   output logic [DATA_W-1:0] vid_q,
   output logic              reset_pulse
);

   logic reset_rise;

   assign reset_rise = wr_ctl & wdata[CTL_RESET_BIT] & ~ctl_q[CTL_RESET_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sys_q       <= DATA_W'(SYS_RESET);
         adp_q       <= DATA_W'(ADP_RESET);
         ctl_q       <= DATA_W'(CTL_RESET);
         vid_q       <= DATA_W'(VID_RESET);
         reset_pulse <= 1'b0;
      end else begin
         if (wr_sys) sys_q <= wdata;
         if (wr_adp) adp_q <= wdata;
         if (wr_ctl) ctl_q <= wdata;
         if (wr_vid) vid_q <= wdata;
         reset_pulse <= reset_rise;
      end
   end

endmodule

// File: rtl/mca_setup_router.sv
module mca_setup_router
   import mca_router_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned SLOT_W     = 3,
   parameter int unsigned WIN_SPAN   = 8,
   parameter int unsigned CTL_ADDR   = 16'h0092,
   parameter int unsigned SYS_ADDR   = 16'h0094,
   parameter int unsigned ADP_ADDR   = 16'h0096,
   parameter int unsigned WIN_BASE   = 16'h0100,
   parameter logic [7:0]  VID_ID_LO  = 8'hFD,
   parameter logic [7:0]  VID_ID_HI  = 8'hEF,
   parameter logic [7:0]  ADP_RD_SET = 8'h70,
   parameter logic [7:0]  IDLE_DATA  = 8'hFF,
   parameter int unsigned VID_OFF    = 2,
   parameter bit          RDATA_REG  = 1'b0,
   localparam int unsigned OFF_W     = $clog2(WIN_SPAN)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              io_rd,
   input  logic              io_wr,
   output logic [DATA_W-1:0] io_rdata,
   input  logic [DATA_W-1:0] planar_rdata,
   input  logic [DATA_W-1:0] slot_rdata,
   output logic              planar_rd,
   output logic              planar_wr,
   output logic              slot_rd,
   output logic              slot_wr,
   output logic [SLOT_W-1:0] slot_idx,
   output logic [OFF_W-1:0]  pos_off,
   output logic              cpu_reset,
   output logic              a20_alt
);

   // Elaboration-time parameter checks
   if (DATA_W != 8) begin : g_bad_data_w
      $error("mca_setup_router: DATA_W must be 8");
   end
   if (SLOT_W < 1 || SLOT_W > ADP_ENABLE_BIT) begin : g_bad_slot_w
      $error("mca_setup_router: SLOT_W must be 1..3");
   end
   if (WIN_SPAN < 4 || (WIN_SPAN & (WIN_SPAN - 1)) != 0) begin : g_bad_span
      $error("mca_setup_router: WIN_SPAN must be a power of two >= 4");
   end
   if ((WIN_BASE % WIN_SPAN) != 0) begin : g_bad_base
      $error("mca_setup_router: WIN_BASE must be aligned to WIN_SPAN");
   end
   if (VID_OFF < 2 || VID_OFF >= WIN_SPAN) begin : g_bad_vid
      $error("mca_setup_router: VID_OFF out of window");
   end

   hit_t              hit;
   logic [OFF_W-1:0]  off;
   route_e            route;
   logic [DATA_W-1:0] sys_q;
   logic [DATA_W-1:0] adp_q;
   logic [DATA_W-1:0] ctl_q;
   logic [DATA_W-1:0] vid_q;
   logic              wr_vid;
   logic [DATA_W-1:0] rd_mux;

   mca_port_decode #(
      .ADDR_W   (ADDR_W),
      .CTL_ADDR (CTL_ADDR),
      .SYS_ADDR (SYS_ADDR),
      .ADP_ADDR (ADP_ADDR),
      .WIN_BASE (WIN_BASE),
      .WIN_SPAN (WIN_SPAN)
   ) i_decode (
      .addr (io_addr),
      .hit  (hit),
      .off  (off)
   );

   mca_window_router #(
      .DATA_W (DATA_W)
   ) i_router (
      .sys_setup (sys_q),
      .adp_setup (adp_q),
      .route     (route)
   );

   assign wr_vid = io_wr & hit.win & (route == RT_VIDEO) & (off == OFF_W'(VID_OFF));

   mca_ctrl_regs #(
      .DATA_W (DATA_W)
   ) i_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wdata       (io_wdata),
      .wr_sys      (io_wr & hit.sys),
      .wr_adp      (io_wr & hit.adp),
      .wr_ctl      (io_wr & hit.ctl),
      .wr_vid      (wr_vid),
      .sys_q       (sys_q),
      .adp_q       (adp_q),
      .ctl_q       (ctl_q),
      .vid_q       (vid_q),
      .reset_pulse (cpu_reset)
   );

   // Target selects
   assign planar_rd = io_rd & hit.win & (route == RT_PLANAR);
   assign planar_wr = io_wr & hit.win & (route == RT_PLANAR);
   assign slot_rd   = io_rd & hit.win & (route == RT_SLOT);
   assign slot_wr   = io_wr & hit.win & (route == RT_SLOT);
   assign slot_idx  = adp_q[SLOT_W-1:0];
   assign pos_off   = off;
   assign a20_alt   = ctl_q[CTL_A20_BIT];

   // Video responder data inside the window
   function automatic logic [DATA_W-1:0] video_data(input logic [OFF_W-1:0] o,
                                                    input logic [DATA_W-1:0] latch);
      if (o == OFF_W'(0))
         return VID_ID_LO;
      else if (o == OFF_W'(1))
         return VID_ID_HI;
      else if (o == OFF_W'(VID_OFF))
         return latch;
      else
         return IDLE_DATA;
   endfunction

   always_comb begin
      rd_mux = IDLE_DATA;
      if (hit.ctl)
         rd_mux = ctl_q;
      else if (hit.sys)
         rd_mux = sys_q;
      else if (hit.adp)
         rd_mux = adp_q | ADP_RD_SET;
      else if (hit.win) begin
         unique case (route)
            RT_PLANAR: rd_mux = planar_rdata;
            RT_VIDEO:  rd_mux = video_data(off, vid_q);
            RT_SLOT:   rd_mux = slot_rdata;
            default:   rd_mux = IDLE_DATA;
         endcase
      end
   end

   // Read data timing variant
   if (RDATA_REG) begin : g_rdata_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            rdata_q <= IDLE_DATA;
         else if (io_rd)
            rdata_q <= rd_mux;
      end
      assign io_rdata = rdata_q;
   end else begin : g_rdata_comb
      assign io_rdata = rd_mux;
   end

endmodule

// File: rtl/mca_router_checker.sv
module mca_router_checker
   import mca_router_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CTL_ADDR = 16'h0092,
   parameter int unsigned WIN_BASE = 16'h0100,
   parameter int unsigned WIN_SPAN = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic [DATA_W-1:0] io_wdata,
   input logic              io_rd,
   input logic              io_wr,
   input logic              planar_rd,
   input logic              planar_wr,
   input logic              slot_rd,
   input logic              slot_wr,
   input logic              cpu_reset,
   input logic              a20_alt,
   input logic [DATA_W-1:0] sys_q
);

   logic in_win;
   logic ctl_wr;

   assign in_win = (io_addr >= ADDR_W'(WIN_BASE)) && (io_addr < ADDR_W'(WIN_BASE + WIN_SPAN));
   assign ctl_wr = io_wr && (io_addr == ADDR_W'(CTL_ADDR));

   assert_planar_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && in_win && !sys_q[SYS_PLANAR_OFF_BIT]) |-> planar_rd);

   assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_reset |-> $past(ctl_wr && io_wdata[CTL_RESET_BIT]));

   assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_reset |=> !cpu_reset);

   assert_a20_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ctl_wr) |-> $stable(a20_alt));

   assert_rd_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (planar_rd || slot_rd) |-> io_rd);

   assert_wr_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (planar_wr || slot_wr) |-> io_wr);

   assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({planar_rd, planar_wr, slot_rd, slot_wr}));

endmodule

bind mca_setup_router mca_router_checker #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .CTL_ADDR (CTL_ADDR),
   .WIN_BASE (WIN_BASE),
   .WIN_SPAN (WIN_SPAN)
) i_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_addr   (io_addr),
   .io_wdata  (io_wdata),
   .io_rd     (io_rd),
   .io_wr     (io_wr),
   .planar_rd (planar_rd),
   .planar_wr (planar_wr),
   .slot_rd   (slot_rd),
   .slot_wr   (slot_wr),
   .cpu_reset (cpu_reset),
   .a20_alt   (a20_alt),
   .sys_q     (sys_q)
);

// File: tb/test_mca_setup_router.sv
module test_mca_setup_router;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_rd = 1'b0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_rdata;
   logic [7:0]  planar_rdata = 8'h3C;
   logic [7:0]  slot_rdata = 8'hA5;
   logic        planar_rd, planar_wr, slot_rd, slot_wr;
   logic [2:0]  slot_idx;
   logic [2:0]  pos_off;
   logic        cpu_reset, a20_alt;

   int n_checks = 0;
   int n_fail   = 0;

   // Reference model state
   logic [7:0] m_sys = 8'hFF;
   logic [7:0] m_adp = 8'h00;
   logic [7:0] m_ctl = 8'h00;
   logic [7:0] m_vid = 8'h00;
   logic       m_pulse = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   mca_setup_router i_mca_setup_router (
      .clk (clk), .rst_n (rst_n),
      .io_addr (io_addr), .io_wdata (io_wdata), .io_rd (io_rd), .io_wr (io_wr),
      .io_rdata (io_rdata), .planar_rdata (planar_rdata), .slot_rdata (slot_rdata),
      .planar_rd (planar_rd), .planar_wr (planar_wr),
      .slot_rd (slot_rd), .slot_wr (slot_wr),
      .slot_idx (slot_idx), .pos_off (pos_off),
      .cpu_reset (cpu_reset), .a20_alt (a20_alt)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // 0 none, 1 planar, 2 video, 3 slot
   function automatic int route_of(input logic [7:0] s, input logic [7:0] a);
      if (!s[7]) return 1;
      if (!s[5]) return 2;
      if (a[3])  return 3;
      return 0;
   endfunction

   function automatic logic in_win(input logic [15:0] ad);
      return ad >= 16'h0100 && ad <= 16'h0107;
   endfunction

   function automatic logic [7:0] exp_rdata(input logic [15:0] ad);
      if (ad == 16'h0092) return m_ctl;
      if (ad == 16'h0094) return m_sys;
      if (ad == 16'h0096) return m_adp | 8'h70;
      if (!in_win(ad)) return 8'hFF;
      case (route_of(m_sys, m_adp))
         1: return planar_rdata;
         3: return slot_rdata;
         2: begin
            if (ad[2:0] == 3'd0) return 8'hFD;
            if (ad[2:0] == 3'd1) return 8'hEF;
            if (ad[2:0] == 3'd2) return m_vid;
            return 8'hFF;
         end
         default: return 8'hFF;
      endcase
   endfunction

   // Expected {planar_rd, planar_wr, slot_rd, slot_wr}
   function automatic logic [3:0] exp_sel(input logic rd, input logic wr, input logic [15:0] ad);
      int r;
      if (!in_win(ad)) return 4'b0000;
      r = route_of(m_sys, m_adp);
      if (r == 1) return {rd, wr, 2'b00};
      if (r == 3) return {2'b00, rd, wr};
      return 4'b0000;
   endfunction

   task automatic access(input logic rd, input logic wr, input logic [15:0] ad,
                         input logic [7:0] d, input string req);
      @(negedge clk);
      check("R8 pulse", {7'd0, cpu_reset}, {7'd0, m_pulse});
      check("R9 a20", {7'd0, a20_alt}, {7'd0, m_ctl[1]});
      io_rd = rd; io_wr = wr; io_addr = ad; io_wdata = d;
      #5;
      check({req, " R11 selects"}, {4'd0, planar_rd, planar_wr, slot_rd, slot_wr},
            {4'd0, exp_sel(rd, wr, ad)});
      check("R5 slot_idx", {5'd0, slot_idx}, {5'd0, m_adp[2:0]});
      if (in_win(ad)) check("R2 pos_off", {5'd0, pos_off}, {5'd0, ad[2:0]});
      if (rd) check({req, " rdata"}, io_rdata, exp_rdata(ad));
      @(posedge clk);
      #1;
      m_pulse = 1'b0;
      if (wr) begin
         if (ad == 16'h0092) begin
            m_pulse = d[0] & ~m_ctl[0];
            m_ctl = d;
         end
         if (ad == 16'h0094) m_sys = d;
         if (ad == 16'h0096) m_adp = d;
         if (ad == 16'h0102 && route_of(m_sys, m_adp) == 2) m_vid = d;
      end
      io_rd = 1'b0; io_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] ad, input string req);
      access(1'b1, 1'b0, ad, 8'h00, req);
   endtask

   task automatic wr(input logic [15:0] ad, input logic [7:0] d, input string req);
      access(1'b0, 1'b1, ad, d, req);
   endtask

   initial begin : watchdog
      #3_000_000;
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : stim
      logic [15:0] addrs [12];
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset values
      check("R1 cpu_reset", {7'd0, cpu_reset}, 8'd0);
      check("R1 a20", {7'd0, a20_alt}, 8'd0);
      rd(16'h0094, "R1 sys");
      rd(16'h0096, "R1 adp");
      rd(16'h0092, "R1 ctl");

      // R2 planar ownership
      wr(16'h0094, 8'h7F, "R10");
      rd(16'h0094, "R10 sys readback");
      rd(16'h0105, "R2 planar read");
      wr(16'h0107, 8'h11, "R2 planar write");

      // R3/R4/R6 integrated video
      wr(16'h0094, 8'hDF, "R10");
      rd(16'h0100, "R3 id lo");
      rd(16'h0101, "R3 id hi");
      rd(16'h0102, "R4 latch reset");
      wr(16'h0102, 8'h5A, "R4 latch write");
      rd(16'h0102, "R4 latch readback");
      wr(16'h0100, 8'h22, "R6 video write dropped");
      rd(16'h0100, "R6 id unchanged");
      rd(16'h0104, "R6 video offset 4");
      wr(16'h0104, 8'h33, "R6 video offset 4 write");

      // R5/R6 adapter forwarding
      wr(16'h0094, 8'hFF, "R10");
      wr(16'h0096, 8'h0B, "R7");
      rd(16'h0096, "R7 adp readback");
      rd(16'h0103, "R5 slot read");
      wr(16'h0106, 8'h44, "R5 slot write");
      wr(16'h0096, 8'h05, "R7");
      rd(16'h0101, "R6 disabled read");
      wr(16'h0102, 8'h66, "R6 disabled write");
      wr(16'h0094, 8'hDF, "R10");
      rd(16'h0102, "R6 latch kept");

      // R8/R9 control byte
      wr(16'h0092, 8'h01, "R8 rise");
      wr(16'h0092, 8'h03, "R8 no rise");
      rd(16'h0092, "R9 readback");
      wr(16'h0092, 8'h00, "R9 clear");
      wr(16'h0092, 8'h02, "R9 a20 only");

      // R10 unmapped
      rd(16'h0090, "R10 unmapped");
      rd(16'h0108, "R10 past window");
      rd(16'h00FF, "R10 before window");

      // Random mix
      addrs = '{16'h0092, 16'h0094, 16'h0096, 16'h0100, 16'h0101, 16'h0102,
                16'h0103, 16'h0104, 16'h0105, 16'h0106, 16'h0107, 16'h0091};
      for (int i = 0; i < 1500; i++) begin
         logic [15:0] a;
         logic [7:0]  d;
         int          k;
         k = $urandom_range(0, 12);
         a = (k == 12) ? 16'($urandom) : addrs[k];
         d = 8'($urandom);
         if (a == 16'h0094) begin
            case ($urandom_range(0, 3))
               0: d = 8'h7F;
               1: d = 8'hDF;
               2: d = 8'hFF;
               default: ;
            endcase
         end
         if (a == 16'h0096 && $urandom_range(0, 1) == 1) d = d | 8'h08;
         planar_rdata = 8'($urandom);
         slot_rdata   = 8'($urandom);
         if ($urandom_range(0, 1) == 1)
            rd(a, "R2 R5 R6 random read");
         else
            wr(a, d, "R2 R5 R6 random write");
      end

      access(1'b0, 1'b0, 16'h0000, 8'h00, "R11 idle");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule